// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM

This block is a synchronous static memory with a single shared data path in which every access moves exactly two data words, one per edge of a double-rate clock pair. A command consists of the load strobe, the direction select and the address. It is taken only on a main-clock rising edge. Write words follow on the complement edge and on the next main edge, and each word carries its own active-low lane selects. Read words come back on the output edge pair after a fixed latency, and the output-enable flag marks the cycles in which the data bus carries a word.

All of this runs in one clock domain at twice the main-clock rate. Each of the four physical edges appears as a one-cycle enable. A mode input picks the edge pair used to drive out read data: either the dedicated output pair or the input pair. The data interface has no back-pressure. A new command may be loaded on every main-clock edge, and read words leave on their fixed schedule whether or not anything is ready to take them, so a consumer must be able to accept every word that is flagged.

The width parameter takes 9, 18 or 36 bits, which gives one, two or four 9-bit lanes. In the 9-bit form, the burst word index is appended below the external address. In the wider forms, the low external address bit seeds the burst word order.

Top module: `ddr2b_sram`

## Requirements
- R1: A command is accepted only when `ld_n` is 0 in a cycle with `k_rise` = 1. Strobe activity in a cycle without `k_rise`, and all inputs in `k_rise` cycles with `ld_n` = 1, leave the stored contents unchanged.
- R2: For an accepted command, `rw` = 1 means read and `rw` = 0 means write.
- R3: Every access moves exactly two words. Commands may be loaded on consecutive `k_rise` edges, and the resulting read bursts come out back to back without gaps.
- R4: Write word 0 is sampled in the first `kb_rise` cycle after the load. Write word 1 is sampled in the next `k_rise` cycle, and that same edge may load a new command. `k_rise` and `kb_rise` never coincide.
- R5: `bws_n` is active low, with one bit per 9-bit lane. Lane l covers data bits 9l+8 down to 9l. A lane whose select is 1 leaves that part of the stored word unchanged.
- R6: Burst addressing. When `DATA_W` is 18 or 36, word 0 goes to `addr` and word 1 goes to `addr` with bit 0 inverted. When `DATA_W` is 9, word 0 goes to {`addr`,0} and word 1 goes to {`addr`,1}.
- R7: Read word 0 appears on `dout`, with `dout_oe` = 1, right after the `RD_LAT`-th output rising enable that follows the load edge. Word 1 follows at the next output falling enable.
- R8: When `single_clk` = 1, the output rising and falling enables are `k_rise` and `kb_rise`. When `single_clk` = 0, they are `c_rise` and `cb_rise`. `dout` changes only after one of these enables.
- R9: While no read word is being driven, including during reset, `dout_oe` is 0 and `dout` is all zeros. `dout_oe` falls at an output rising enable that has no word due.
- R10: A read loaded on the `k_rise` edge that captures write word 1 of a write to the same address returns the newly written data for both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; every edge event is an enable on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| k_rise | input | 1 | Main clock rising edge enable |
| kb_rise | input | 1 | Complement of main clock rising edge enable |
| c_rise | input | 1 | Output clock rising edge enable |
| cb_rise | input | 1 | Complement of output clock rising edge enable |
| single_clk | input | 1 | 1: drive read data on the main clock pair |
| ld_n | input | 1 | Active-low command load strobe |
| rw | input | 1 | 1 read, 0 write |
| addr | input | ADDR_W | Command address |
| din | input | DATA_W | Write data word |
| bws_n | input | DATA_W/9 | Active-low lane write selects |
| dout | output | DATA_W | Read data word |
| dout_oe | output | 1 | High while `dout` carries a read word |

## Verification
The bench builds two copies side by side from the same stimulus. One has `DATA_W`=36, `ADDR_W`=5 and `RD_LAT`=2. The other has `DATA_W`=9 and `ADDR_W`=4. The wide copy exercises the odd-start burst order and the four-lane partial writes. The narrow copy exercises the appended word index, and because its address space is aliased, later writes overwrite earlier ones. A latency of two makes the wait through the read pipeline visible. Under that latency, the output pair and the input pair give different edge counts, which the latency checks for both values of `single_clk` can tell apart.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LOW  = 2'd1,
    WR_HIGH = 2'd2
  } wr_step_e;

endpackage

// File: rtl/ddr2b_addr_gen.sv
module ddr2b_addr_gen #(
  parameter int ADDR_W = 5,
  parameter int NARROW = 0,
  parameter int IAW    = ADDR_W + NARROW
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IAW-1:0]    ia0,
  output logic [IAW-1:0]    ia1
);

  generate
    if (NARROW != 0) begin : g_narrow
      // word index appended below the external address
      assign ia0 = {addr, 1'b0};
      assign ia1 = {addr, 1'b1};
    end else begin : g_wide
      // one-bit linear counter seeded by the low address bit
      assign ia0 = addr;
      assign ia1 = {addr[ADDR_W-1:1], ~addr[0]};
    end
  endgenerate

endmodule

// File: rtl/ddr2b_wr_engine.sv
module ddr2b_wr_engine
  import ddr2b_pkg::*;
#(
  parameter int IAW    = 5,
  parameter int DATA_W = 36,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              k_rise,
  input  logic              kb_rise,
  input  logic              wr_load,
  input  logic [IAW-1:0]    ia0,
  input  logic [IAW-1:0]    ia1,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  bws_n,
  output logic              we,
  output logic [IAW-1:0]    waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  wlane
);

  wr_step_e       st;
  logic [IAW-1:0] a0_q;
  logic [IAW-1:0] a1_q;

  // word 0 lands on the complement edge, word 1 on the next main edge
  assign we    = (kb_rise && st == WR_LOW) || (k_rise && st == WR_HIGH);
  assign waddr = (st == WR_LOW) ? a0_q : a1_q;
  assign wdata = din;
  assign wlane = ~bws_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= WR_IDLE;
      a0_q <= '0;
      a1_q <= '0;
    end else if (k_rise) begin
      if (wr_load) begin
        st   <= WR_LOW;
        a0_q <= ia0;
        a1_q <= ia1;
      end else begin
        st <= WR_IDLE;
      end
    end else if (kb_rise && st == WR_LOW) begin
      st <= WR_HIGH;
    end
  end

endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array
  import ddr2b_pkg::*;
#(
  parameter int IAW    = 5,
  parameter int DATA_W = 36,
  parameter int LANES  = DATA_W / LANE_W,
  parameter int DEPTH  = 1 << IAW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IAW-1:0]    waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wlane,
  input  logic [IAW-1:0]    raddr0,
  input  logic [IAW-1:0]    raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] bmask;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign bmask[l*LANE_W +: LANE_W] = {LANE_W{wlane[l]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= (mem[waddr] & ~bmask) | (wdata & bmask);
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/ddr2b_rd_pipe.sv
module ddr2b_rd_pipe #(
  parameter int IAW    = 5,
  parameter int DATA_W = 36,
  parameter int RD_LAT = 2,
  parameter int LAST   = RD_LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              o_rise,
  input  logic              o_fall,
  input  logic              rd_load,
  input  logic [IAW-1:0]    ia0,
  input  logic [IAW-1:0]    ia1,
  input  logic [DATA_W-1:0] rdata0,
  input  logic [DATA_W-1:0] rdata1,
  output logic [IAW-1:0]    raddr0,
  output logic [IAW-1:0]    raddr1,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  logic [RD_LAT-1:0]           vld;
  logic [RD_LAT-1:0][IAW-1:0]  sa0;
  logic [RD_LAT-1:0][IAW-1:0]  sa1;
  logic [IAW-1:0]              a1_hold;
  logic                        pend;

  // stage 0 takes new reads; it shifts on output rising enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld[0] <= 1'b0;
      sa0[0] <= '0;
      sa1[0] <= '0;
    end else if (o_rise || rd_load) begin
      vld[0] <= rd_load;
      sa0[0] <= ia0;
      sa1[0] <= ia1;
    end
  end

  genvar i;
  generate
    for (i = 1; i < RD_LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[i] <= 1'b0;
          sa0[i] <= '0;
          sa1[i] <= '0;
        end else if (o_rise) begin
          vld[i] <= vld[i-1];
          sa0[i] <= sa0[i-1];
          sa1[i] <= sa1[i-1];
        end
      end
    end
  endgenerate

  assign raddr0 = sa0[LAST];
  assign raddr1 = a1_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
      pend    <= 1'b0;
      a1_hold <= '0;
    end else if (o_rise) begin
      if (vld[LAST]) begin
        dout    <= rdata0;
        dout_oe <= 1'b1;
        pend    <= 1'b1;
        a1_hold <= sa1[LAST];
      end else begin
        dout    <= '0;
        dout_oe <= 1'b0;
        pend    <= 1'b0;
      end
    end else if (o_fall && pend) begin
      dout <= rdata1;
      pend <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 5,
  parameter int RD_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     k_rise,
  input  logic                     kb_rise,
  input  logic                     c_rise,
  input  logic                     cb_rise,
  input  logic                     single_clk,
  input  logic                     ld_n,
  input  logic                     rw,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        din,
  input  logic [DATA_W/LANE_W-1:0] bws_n,
  output logic [DATA_W-1:0]        dout,
  output logic                     dout_oe
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int NARROW = (DATA_W == LANE_W) ? 1 : 0;
  localparam int IAW    = ADDR_W + NARROW;
  localparam int DEPTH  = 1 << IAW;

  logic              o_rise, o_fall, load, rd_load, wr_load;
  logic [IAW-1:0]    ia0, ia1, waddr, raddr0, raddr1;
  logic [DATA_W-1:0] wdata, rdata0, rdata1;
  logic [LANES-1:0]  wlane;
  logic              we;

  assign o_rise  = single_clk ? k_rise  : c_rise;
  assign o_fall  = single_clk ? kb_rise : cb_rise;
  assign load    = k_rise && !ld_n;
  assign rd_load = load && rw;
  assign wr_load = load && !rw;

  ddr2b_addr_gen #(.ADDR_W(ADDR_W), .NARROW(NARROW), .IAW(IAW)) u_addr (
    .addr(addr), .ia0(ia0), .ia1(ia1)
  );

  ddr2b_wr_engine #(.IAW(IAW), .DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .kb_rise(kb_rise),
    .wr_load(wr_load), .ia0(ia0), .ia1(ia1), .din(din), .bws_n(bws_n),
    .we(we), .waddr(waddr), .wdata(wdata), .wlane(wlane)
  );

  ddr2b_array #(.IAW(IAW), .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .wlane(wlane),
    .raddr0(raddr0), .raddr1(raddr1), .rdata0(rdata0), .rdata1(rdata1)
  );

  ddr2b_rd_pipe #(.IAW(IAW), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n), .o_rise(o_rise), .o_fall(o_fall),
    .rd_load(rd_load), .ia0(ia0), .ia1(ia1), .rdata0(rdata0), .rdata1(rdata1),
    .raddr0(raddr0), .raddr1(raddr1), .dout(dout), .dout_oe(dout_oe)
  );

endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              k_rise,
  input logic              kb_rise,
  input logic              c_rise,
  input logic              cb_rise,
  input logic              single_clk,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);

  logic o_rise, o_fall;
  assign o_rise = single_clk ? k_rise  : c_rise;
  assign o_fall = single_clk ? kb_rise : cb_rise;

  // R9: bus is quiet whenever no word is flagged
  p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  // R7: a burst starts only after an output rising enable
  p_drive_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(o_rise));

  // R3: a burst ends only at a rising enable, so both words are flagged
  p_drive_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> $past(o_rise));

  // R8: data moves only after a selected output edge
  p_dout_on_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(o_rise || o_fall));

  // R4: the main and complement edges never fall in the same cycle
  p_edge_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(k_rise && kb_rise));

endmodule

bind ddr2b_sram ddr2b_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .kb_rise(kb_rise),
  .c_rise(c_rise), .cb_rise(cb_rise), .single_clk(single_clk),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_ddr2b_sram.sv
module test_ddr2b_sram;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [35:0] d;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        k_rise, kb_rise, c_rise, cb_rise;
  logic        single_clk = 1'b1;
  logic        ld_n = 1'b1;
  logic        rw = 1'b0;
  logic [4:0]  addr = '0;
  logic [35:0] din = '0;
  logic [3:0]  bws_n = '1;
  logic [35:0] dout_w;
  logic        oe_w;
  logic [8:0]  dout_n;
  logic        oe_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [35:0] ref_w [32];
  logic [8:0]  ref_n [32];
  exp_t q_w[$];
  exp_t q_n[$];

  ddr2b_sram #(.DATA_W(36), .ADDR_W(5), .RD_LAT(2)) i_ddr2b_sram (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .kb_rise(kb_rise),
    .c_rise(c_rise), .cb_rise(cb_rise), .single_clk(single_clk),
    .ld_n(ld_n), .rw(rw), .addr(addr), .din(din), .bws_n(bws_n),
    .dout(dout_w), .dout_oe(oe_w)
  );

  ddr2b_sram #(.DATA_W(9), .ADDR_W(4), .RD_LAT(2)) i_ddr2b_sram_narrow (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .kb_rise(kb_rise),
    .c_rise(c_rise), .cb_rise(cb_rise), .single_clk(single_clk),
    .ld_n(ld_n), .rw(rw), .addr(addr[3:0]), .din(din[8:0]), .bws_n(bws_n[0:0]),
    .dout(dout_n), .dout_oe(oe_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compares each flagged word against the scoreboard
  task automatic monitor();
    bit o0, o1;
    exp_t e;
    if (!rst_n) return;
    o0 = single_clk ? k_rise : c_rise;
    o1 = single_clk ? kb_rise : cb_rise;
    if (o0 || o1) begin
      if (oe_w) begin
        if (q_w.size() == 0) check(1'b0, "R3", dout_w, '0, "wide word with nothing due");
        else begin
          e = q_w.pop_front();
          check(dout_w === e.d, e.tag, dout_w, e.d, "wide read word");
        end
      end
      if (oe_n) begin
        if (q_n.size() == 0) check(1'b0, "R3", {27'd0, dout_n}, '0, "narrow word with nothing due");
        else begin
          e = q_n.pop_front();
          check({27'd0, dout_n} === e.d, e.tag, {27'd0, dout_n}, e.d, "narrow read word");
        end
      end
    end
  endtask

  // edge enables: main edge on even cycles, output pair offset by one
  initial begin
    k_rise = 1'b1; kb_rise = 1'b0; c_rise = 1'b0; cb_rise = 1'b1;
    forever begin
      @(negedge clk);
      monitor();
      cyc++;
      k_rise  = (cyc % 2 == 0);
      kb_rise = (cyc % 2 == 1);
      c_rise  = (cyc % 2 == 1);
      cb_rise = (cyc % 2 == 0);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    for (int j = 0; j < n; j++) begin
      step();
      step();
    end
  endtask

  // R4 R5 R6: write burst, reference updated per active-low lane select
  task automatic wr(logic [4:0] a, logic [35:0] w0, logic [3:0] m0,
                    logic [35:0] w1, logic [3:0] m1);
    logic [4:0] a1;
    ld_n = 1'b0; rw = 1'b0; addr = a;
    step();
    ld_n = 1'b1; din = w0; bws_n = m0;
    step();
    din = w1; bws_n = m1;
    a1 = {a[4:1], ~a[0]};
    for (int l = 0; l < 4; l++) begin
      if (!m0[l]) ref_w[a][l*9 +: 9] = w0[l*9 +: 9];
      if (!m1[l]) ref_w[a1][l*9 +: 9] = w1[l*9 +: 9];
    end
    if (!m0[0]) ref_n[{a[3:0], 1'b0}] = w0[8:0];
    if (!m1[0]) ref_n[{a[3:0], 1'b1}] = w1[8:0];
  endtask

  task automatic push_read(logic [4:0] a, string tag);
    q_w.push_back('{ref_w[a], tag});
    q_w.push_back('{ref_w[{a[4:1], ~a[0]}], tag});
    q_n.push_back('{{27'd0, ref_n[{a[3:0], 1'b0}]}, tag});
    q_n.push_back('{{27'd0, ref_n[{a[3:0], 1'b1}]}, tag});
  endtask

  task automatic rd(logic [4:0] a, string tag);
    ld_n = 1'b0; rw = 1'b1; addr = a;
    push_read(a, tag);
    step();
    ld_n = 1'b1;
    step();
  endtask

  function automatic logic [35:0] pat(int k);
    return {9'(k * 3 + 1), 9'(k * 5 + 2), 9'(k * 7 + 3), 9'(k + 200)};
  endfunction

  task automatic latency_check(logic [4:0] a, int quiet_at, string tag);
    ld_n = 1'b0; rw = 1'b1; addr = a;
    push_read(a, tag);
    step();
    ld_n = 1'b1;
    for (int j = 1; j < quiet_at; j++) step();
    check(oe_w == 1'b0, tag, {35'd0, oe_w}, 36'd0, "flag before latency");
    step();
    check(oe_w == 1'b1 && oe_n == 1'b1, tag, {35'd0, oe_w}, 36'd1, "flag at latency");
  endtask

  initial begin
    for (int j = 0; j < 4; j++) step();
    // R9: reset state
    check(oe_w == 1'b0 && dout_w == '0, "R9", dout_w, '0, "wide reset state");
    check(oe_n == 1'b0 && dout_n == '0, "R9", {27'd0, dout_n}, '0, "narrow reset state");
    rst_n = 1'b1;
    step();
    while (!k_rise) step();

    // fill every address, single-clock mode
    for (int i = 0; i < 32; i++) wr(5'(i), pat(i), 4'b0000, pat(i + 40), 4'b0000);
    idle(2);

    rd(5'd6, "R2");
    rd(5'd7, "R6");
    rd(5'd10, "R3");
    rd(5'd11, "R3");
    idle(6);

    // R5: partial lane writes
    wr(5'd9, 36'hFFFF_FFFF_F, 4'b0101, 36'h1234_5678_9, 4'b1010);
    idle(1);
    rd(5'd9, "R5");
    wr(5'd16, 36'hABCD_EF01_2, 4'b1110, 36'h0F0F_0F0F_0, 4'b0111);
    idle(1);
    rd(5'd16, "R5");
    idle(6);

    // R10: read loaded on the edge taking write word 1
    wr(5'd12, 36'h5A5A_5A5A_5, 4'b0000, 36'hC3C3_C3C3_C, 4'b0000);
    rd(5'd12, "R10");
    idle(6);

    // R1: strobe on the complement edge and inputs with strobe high are ignored
    step();
    ld_n = 1'b0; rw = 1'b0; addr = 5'd20; din = '1; bws_n = 4'b0000;
    step();
    ld_n = 1'b1; rw = 1'b0; addr = 5'd21;
    idle(2);
    rd(5'd20, "R1");
    rd(5'd21, "R1");
    idle(6);

    // R7: latency on the main pair
    latency_check(5'd3, 4, "R7");
    step();
    idle(6);

    // R9: idle bus
    check(oe_w == 1'b0 && dout_w == '0, "R9", dout_w, '0, "wide idle bus");
    check(oe_n == 1'b0 && dout_n == '0, "R9", {27'd0, dout_n}, '0, "narrow idle bus");

    // R8: output clock pair
    single_clk = 1'b0;
    idle(2);
    latency_check(5'd25, 3, "R8");
    idle(6);
    rd(5'd4, "R8");
    rd(5'd31, "R8");
    wr(5'd13, 36'h0_1111_2222, 4'b0011, 36'h3_3333_4444, 4'b1100);
    rd(5'd13, "R10");
    idle(8);

    check(q_w.size() == 0, "R3", 36'(q_w.size()), '0, "wide words left undelivered");
    check(q_n.size() == 0, "R3", 36'(q_n.size()), '0, "narrow words left undelivered");
    check(oe_w == 1'b0 && oe_n == 1'b0, "R9", {35'd0, oe_w}, '0, "flag low after drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule